// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog built around an 8-bit up-counter that advances once per prescaler tick. The prescaler divides the system clock by 32 times a power of two chosen by a 3-bit code, so the eight codes span ratios from 1/32 to 1/4096. When the counter rolls over from its top value, the block does one of two things. In interval mode it sets a sticky flag and pulses an interrupt. In reset mode it pulses a reset request.

Software reaches two byte-wide registers over a simple bus: the count and the control word. Reads return the selected byte directly. A write carries 16 bits. The upper byte must hold the register's own key, or the write is dropped without any trace. This makes a stray store very unlikely to disturb the timer.

Top module: `keyed_wdt`

## Requirements
- R1: A write to address 0 whose bits 15:8 equal 0x5A loads bits 7:0 into the counter and restarts the prescaler from zero, so the next count step comes a full prescaler period later.
- R2: A write to address 1 whose bits 15:8 equal 0xA5 updates the control byte from bits 7:0. The layout is: bit 7 enable, bit 6 mode (1 = reset request), bit 5 overflow flag, bits 4:3 always read 0, bits 2:0 clock-select code.
- R3: A write whose key byte differs from the addressed register's key changes nothing: the counter, the control byte and the flag keep their values.
- R4: bus_rdata shows the counter when bus_addr is 0 and the control byte when bus_addr is 1, combinationally, with no key involved.
- R5: After reset the counter reads 0x00, the control byte reads 0x00 (disabled, code 0, ratio 1/32), and both irq_interval and rst_req are low.
- R6: While enable is 0, the prescaler is held at zero and the counter keeps its value.
- R7: While enable is 1, the counter increments once every 32·2^code clocks, and the first increment comes 32·2^code clocks after the write that enabled the timer or loaded the counter.
- R8: The counter wraps from 0xFF to 0x00, so a free-running overflow period is 256·32·2^code clocks.
- R9: In interval mode (bit 6 = 0), an overflow sets the flag and raises irq_interval for exactly one clock, in the same cycle the counter reads 0x00. rst_req stays low.
- R10: In reset mode (bit 6 = 1), an overflow raises rst_req for exactly one clock. The flag is not set and irq_interval stays low.
- R11: The flag stays set until a keyed control write carries 0 in bit 5. Writing 1 there leaves the flag as it is and cannot set it. An overflow in the same cycle as a clearing write leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 1 | Register select: 0 counter, 1 control |
| bus_wr | input | 1 | Write strobe for one clock |
| bus_wdata | input | 16 | Key byte in 15:8, value in 7:0 |
| bus_rdata | output | 8 | Selected register byte |
| irq_interval | output | 1 | One-clock interrupt on overflow in interval mode |
| rst_req | output | 1 | One-clock reset request on overflow in reset mode |

## Verification
The bench measures the clocks from an enabling write to the first count step and on to the overflow for all eight select codes. A prescaler mask off by one bit, or a wrong code-to-ratio mapping, shows up there as a wrong distance. It measures the full 256-step period between two interrupts for the two fastest codes, which catches a counter that skips or repeats a value at the wrap. It sends writes with foreign keys, including the other register's key, and a design that ignored the key or compared the wrong byte would let the value through. It also reloads the counter in the middle of a prescaler period: a design that did not restart the prescaler would step early. Finally it checks that the flag neither clears on a written 1 nor sets in reset mode.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

   // Register select on the bus
   typedef enum logic {
      WDT_REG_COUNT = 1'b0,
      WDT_REG_CTRL  = 1'b1
   } wdt_reg_e;

   localparam int unsigned WDT_NUM_REGS = 2;

endpackage

// File: rtl/wdt_keygate.sv
module wdt_keygate
   import wdt_pkg::*;
#(
   parameter int unsigned BYTE_W = 8,
   parameter logic [BYTE_W-1:0] COUNT_KEY = 8'h5A,
   parameter logic [BYTE_W-1:0] CTRL_KEY = 8'hA5,
   localparam int unsigned WORD_W = 2 * BYTE_W
)(
   input  logic              bus_wr,
   input  logic              bus_addr,
   input  logic [WORD_W-1:0] bus_wdata,
   output logic              count_we,
   output logic              ctrl_we,
   output logic [BYTE_W-1:0] wr_byte
);

   logic [WDT_NUM_REGS-1:0][BYTE_W-1:0] key_tab;
   logic [WDT_NUM_REGS-1:0]             we_vec;
   logic [BYTE_W-1:0]                   key_byte;

   assign key_tab[WDT_REG_COUNT] = COUNT_KEY;
   assign key_tab[WDT_REG_CTRL]  = CTRL_KEY;
   assign key_byte = bus_wdata[WORD_W-1:BYTE_W];
   assign wr_byte  = bus_wdata[BYTE_W-1:0];

   for (genvar g = 0; g < WDT_NUM_REGS; g++) begin : g_reg
      assign we_vec[g] = bus_wr && (bus_addr == g[0]) && (key_byte == key_tab[g]);
   end

   assign count_we = we_vec[WDT_REG_COUNT];
   assign ctrl_we  = we_vec[WDT_REG_CTRL];

endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
   parameter int unsigned BASE_LOG2 = 5,
   parameter int unsigned SEL_W = 3,
   localparam int unsigned NUM_CODES = 2 ** SEL_W,
   localparam int unsigned PRE_W = BASE_LOG2 + NUM_CODES - 1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);

   logic [PRE_W-1:0]     pre_q;
   logic [NUM_CODES-1:0] tick_by_code;

   if (BASE_LOG2 < 1) begin : g_bad_base
      $error("wdt_prescaler: BASE_LOG2 must be at least 1");
   end

   // Code k ends a period when the low BASE_LOG2+k bits are all ones
   for (genvar k = 0; k < NUM_CODES; k++) begin : g_code
      assign tick_by_code[k] = &pre_q[BASE_LOG2+k-1:0];
   end

   assign tick = run && !restart && tick_by_code[sel];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
      end else if (!run || restart) begin
         pre_q <= '0;
      end else begin
         pre_q <= pre_q + 1'b1;
      end
   end

   AST_PRE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (pre_q == '0)) else $error("prescaler not held while disabled"); // R6

   AST_PRE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (pre_q == '0) && !tick) else $error("prescaler not restarted"); // R1

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
   parameter int unsigned CNT_W = 8
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             step,
   output logic [CNT_W-1:0] cnt_q,
   output logic             wrap
);

   // A load in the same cycle as a step wins; no overflow is reported then
   assign wrap = step && !load && (&cnt_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (step) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !step) |=> $stable(cnt_q)) else $error("counter moved without a step"); // R6

   AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt_q == $past(load_val))) else $error("counter load lost"); // R1

   AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (cnt_q == '0)) else $error("counter did not wrap to zero"); // R8

endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
   import wdt_pkg::*;
#(
   parameter int unsigned CNT_W = 8,
   parameter int unsigned SEL_W = 3,
   parameter int unsigned BASE_LOG2 = 5,
   parameter logic [CNT_W-1:0] COUNT_KEY = 8'h5A,
   parameter logic [CNT_W-1:0] CTRL_KEY = 8'hA5,
   localparam int unsigned WORD_W = 2 * CNT_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_addr,
   input  logic              bus_wr,
   input  logic [WORD_W-1:0] bus_wdata,
   output logic [CNT_W-1:0]  bus_rdata,
   output logic              irq_interval,
   output logic              rst_req
);

   localparam int unsigned EN_BIT   = CNT_W - 1;
   localparam int unsigned MODE_BIT = CNT_W - 2;
   localparam int unsigned FLAG_BIT = CNT_W - 3;
   localparam logic [CNT_W-1:0] SEL_MASK  = CNT_W'((1 << SEL_W) - 1);
   localparam logic [CNT_W-1:0] FLAG_MASK = CNT_W'(1) << FLAG_BIT;
   localparam logic [CNT_W-1:0] WR_MASK   = (CNT_W'(1) << EN_BIT) | (CNT_W'(1) << MODE_BIT) | SEL_MASK;

   if (CNT_W < SEL_W + 3) begin : g_bad_width
      $error("keyed_wdt: control byte too narrow for the select field");
   end
   if (COUNT_KEY == CTRL_KEY) begin : g_bad_keys
      $error("keyed_wdt: the two register keys must differ");
   end

   logic             count_we, ctrl_we;
   logic [CNT_W-1:0] wr_byte;
   logic [CNT_W-1:0] ctl_q, ctl_d;
   logic [CNT_W-1:0] cnt_q;
   logic             run, reset_mode, tick, wrap, set_flag;
   logic             irq_q, rreq_q;
   logic [SEL_W-1:0] sel;

   wdt_keygate #(
      .BYTE_W    (CNT_W),
      .COUNT_KEY (COUNT_KEY),
      .CTRL_KEY  (CTRL_KEY)
   ) u_keygate (
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .count_we  (count_we),
      .ctrl_we   (ctrl_we),
      .wr_byte   (wr_byte)
   );

   assign run        = ctl_q[EN_BIT];
   assign reset_mode = ctl_q[MODE_BIT];
   assign sel        = ctl_q[SEL_W-1:0];

   wdt_prescaler #(
      .BASE_LOG2 (BASE_LOG2),
      .SEL_W     (SEL_W)
   ) u_prescaler (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .restart (count_we),
      .sel     (sel),
      .tick    (tick)
   );

   wdt_counter #(
      .CNT_W (CNT_W)
   ) u_counter (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (count_we),
      .load_val (wr_byte),
      .step     (tick),
      .cnt_q    (cnt_q),
      .wrap     (wrap)
   );

   assign set_flag = wrap && !reset_mode;

   // Control update: flag is clear-only from the bus, set only by overflow
   always_comb begin
      ctl_d = ctl_q;
      if (ctrl_we) begin
         ctl_d = (wr_byte & WR_MASK) | (ctl_q & wr_byte & FLAG_MASK);
      end
      if (set_flag) begin
         ctl_d[FLAG_BIT] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q  <= '0;
         irq_q  <= 1'b0;
         rreq_q <= 1'b0;
      end else begin
         ctl_q  <= ctl_d;
         irq_q  <= set_flag;
         rreq_q <= wrap && reset_mode;
      end
   end

   assign irq_interval = irq_q;
   assign rst_req      = rreq_q;
   assign bus_rdata    = (bus_addr == WDT_REG_CTRL) ? ctl_q : cnt_q;

   AST_KEY_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && (bus_wdata[WORD_W-1:CNT_W] != CTRL_KEY))
      |=> ((ctl_q & WR_MASK) == ($past(ctl_q) & WR_MASK))) else $error("control changed by a write without its key"); // R3

   AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_interval |=> !irq_interval) else $error("interrupt longer than one clock"); // R9

   AST_IRQ_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      irq_interval |-> (cnt_q == '0) && ctl_q[FLAG_BIT]) else $error("interrupt without wrap and flag"); // R9

   AST_RST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req) else $error("reset request longer than one clock"); // R10

   AST_OUT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(rst_req && irq_interval)) else $error("both overflow outputs active"); // R10

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_q[FLAG_BIT] && !ctrl_we) |=> ctl_q[FLAG_BIT]) else $error("flag dropped without a clearing write"); // R11

   AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_q & ~(WR_MASK | FLAG_MASK)) == '0) else $error("reserved control bits set"); // R2

endmodule

// File: tb/test_keyed_wdt.sv
module test_keyed_wdt;

   localparam int WD_LIMIT = 190000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_addr = 1'b0;
   logic        bus_wr = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        irq_interval;
   logic        rst_req;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   keyed_wdt i_keyed_wdt (
      .clk          (clk),
      .rst_n        (rst_n),
      .bus_addr     (bus_addr),
      .bus_wr       (bus_wr),
      .bus_wdata    (bus_wdata),
      .bus_rdata    (bus_rdata),
      .irq_interval (irq_interval),
      .rst_req      (rst_req)
   );

   always #10 clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == WD_LIMIT) begin
         errors++;
         $display("FAIL watchdog: run hung, actual cycle %0d expected below %0d", cyc, WD_LIMIT);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // Caller sits just after a falling edge; returns just after the next one
   task automatic wr(input logic a, input logic [15:0] d);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_wr    = 1'b0;
      bus_wdata = 16'h0000;
   endtask

   task automatic rd(input logic a, output logic [7:0] v);
      bus_addr = a;
      #1;
      v = bus_rdata;
   endtask

   // Clocks from now until the chosen output is seen high
   task automatic wait_out(input bit want_rst, input int limit, output int n, output bit other_seen);
      int start;
      start = cyc;
      other_seen = 1'b0;
      for (int i = 0; i < limit; i++) begin
         if (want_rst ? rst_req : irq_interval) break;
         if (want_rst ? irq_interval : rst_req) other_seen = 1'b1;
         @(negedge clk);
      end
      n = cyc - start;
   endtask

   task automatic t_reset();
      logic [7:0] v;
      rd(1'b0, v); chk("R5", "counter after reset", v, 8'h00);
      rd(1'b1, v); chk("R5", "control after reset", v, 8'h00);
      chk("R5", "irq after reset", irq_interval, 0);
      chk("R5", "rst_req after reset", rst_req, 0);
      repeat (200) @(negedge clk);
      rd(1'b0, v); chk("R6", "counter idle after reset", v, 8'h00);
   endtask

   task automatic t_regs();
      logic [7:0] v;
      wr(1'b0, 16'h5A37);
      rd(1'b0, v); chk("R1", "keyed counter load", v, 8'h37);
      wr(1'b1, 16'hA53B);
      rd(1'b1, v); chk("R2", "control layout, reserved and flag not writable", v, 8'h03);
      bus_wdata = 16'hFFFF;
      rd(1'b0, v); chk("R4", "counter read ignores data bus", v, 8'h37);
      rd(1'b1, v); chk("R4", "control read by address", v, 8'h03);
      bus_wdata = 16'h0000;
      repeat (300) @(negedge clk);
      rd(1'b0, v); chk("R6", "counter holds while disabled", v, 8'h37);
   endtask

   task automatic t_code(input int s);
      logic [7:0] v;
      int r, n;
      bit other;
      r = 32 << s;
      wr(1'b1, 16'hA500);
      wr(1'b0, 16'h5AFE);
      wr(1'b1, 16'hA580 | 16'(s));
      repeat (r - 1) @(negedge clk);
      rd(1'b0, v); chk("R7", $sformatf("no step before period, code %0d", s), v, 8'hFE);
      @(negedge clk);
      rd(1'b0, v); chk("R7", $sformatf("step after one period, code %0d", s), v, 8'hFF);
      wait_out(1'b0, 2 * r + 4, n, other);
      chk("R8", $sformatf("overflow distance, code %0d", s), n, r);
      rd(1'b0, v); chk("R8", $sformatf("wrap to zero, code %0d", s), v, 8'h00);
      rd(1'b1, v); chk("R9", $sformatf("flag set, code %0d", s), v, 8'hA0 | s);
      chk("R9", "no reset request in interval mode", rst_req | other, 0);
   endtask

   task automatic t_full(input int s);
      int r, n;
      bit other;
      r = 32 << s;
      wr(1'b1, 16'hA580 | 16'(s));
      wait_out(1'b0, 256 * r + 8, n, other);
      @(negedge clk);
      chk("R9", $sformatf("interrupt one clock wide, code %0d", s), irq_interval, 0);
      wait_out(1'b0, 256 * r + 8, n, other);
      chk("R8", $sformatf("full overflow period, code %0d", s), n + 1, 256 * r);
      chk("R9", "no reset request during full period", other, 0);
   endtask

   task automatic t_reject();
      logic [7:0] v;
      int n;
      bit other;
      wr(1'b1, 16'hA500);
      wr(1'b0, 16'h5AFE);
      wr(1'b1, 16'hA580);
      wait_out(1'b0, 200, n, other);
      wr(1'b1, 16'hA520);
      rd(1'b1, v); chk("R11", "writing 1 keeps flag, disables", v, 8'h20);
      wr(1'b1, 16'h5A87);
      rd(1'b1, v); chk("R3", "control write with counter key", v, 8'h20);
      wr(1'b1, 16'h0000);
      rd(1'b1, v); chk("R3", "control write with zero key keeps flag", v, 8'h20);
      rd(1'b0, v);
      n = v;
      wr(1'b0, 16'hA555);
      wr(1'b0, 16'h5B55);
      wr(1'b0, 16'h0055);
      repeat (100) @(negedge clk);
      rd(1'b0, v); chk("R3", "counter after wrong keys", v, n);
      wr(1'b1, 16'hA500);
      rd(1'b1, v); chk("R11", "keyed write of 0 clears flag", v, 8'h00);
   endtask

   task automatic t_rstmode();
      logic [7:0] v;
      int n;
      bit other;
      wr(1'b0, 16'h5AFE);
      wr(1'b1, 16'hA5C0);
      wait_out(1'b1, 200, n, other);
      chk("R10", "reset request distance", n, 64);
      chk("R10", "no interrupt in reset mode", other | irq_interval, 0);
      @(negedge clk);
      chk("R10", "reset request one clock wide", rst_req, 0);
      rd(1'b1, v); chk("R10", "flag not set in reset mode", v, 8'hC0);
      wr(1'b1, 16'hA500);
   endtask

   task automatic t_restart();
      logic [7:0] v;
      wr(1'b1, 16'hA580);
      repeat (45) @(negedge clk);
      wr(1'b0, 16'h5A80);
      repeat (31) @(negedge clk);
      rd(1'b0, v); chk("R1", "no early step after reload", v, 8'h80);
      @(negedge clk);
      rd(1'b0, v); chk("R1", "step one full period after reload", v, 8'h81);
      wr(1'b1, 16'hA500);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regs();
      for (int s = 0; s < 8; s++) t_code(s);
      t_full(0);
      t_full(1);
      t_reject();
      t_rstmode();
      t_restart();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule